// File: doc/BRIEF.md
# Interrupt Moderation Timer

This block spaces out interrupt deliveries on a set of vectors. Each vector has its own 8-bit interval held in a register. After a vector delivers an interrupt, its countdown counter loads that interval, and any request that arrives while the counter is non-zero waits until the counter has drained to zero. All vectors share one 8-bit resolution value. This value drives a prescaler on a fixed base time tick: with resolution N, every counter moves down by one on every (N+1)-th base tick. With a nominal base tick of 0.68 us, resolution N gives a step of (N+1) x 0.68 us.

An interval of zero turns moderation off for that vector, so each request goes out on the next clock. A group-wide flush strobe releases every waiting request at once, whatever its counter holds. Requests that pile up while a vector waits merge into a single delivery pulse. The surrounding controller keeps cause and mask state and feeds this block its pending requests. It then turns the `fire` pulses into messages or into a level interrupt. The last vector index is usually given to the shared legacy line.

Top module: `irq_moderator`

## Requirements
- R1: After reset, `fire` is all zero, every interval is 0, every counter is 0 and the resolution is 0. A request on any vector right after reset is therefore delivered on the next clock.
- R2: With resolution N, a running counter decrements on each (N+1)-th `base_tick` pulse, counting from the most recent resolution write or wrap.
- R3: A write to `res_we` restarts the prescaler phase at 0, and a base tick in the same cycle as the write does not decrement any counter.
- R4: `intv_we` with `intv_sel` = v (binary vector index) sets the interval of vector v only. Each vector moderates independently of the others.
- R5: A vector whose interval is 0 delivers a request held high on every clock as a `fire` pulse on every following clock.
- R6: A request (or a stored pending request) on a vector whose counter is 0 gives `fire` high for one cycle on the next clock, and the counter then holds that vector's interval.
- R7: A request on a vector whose counter is non-zero gives no `fire` until the counter has reached 0. It is then delivered on the clock after the counter reaches 0.
- R8: Any number of requests that arrive during one countdown produce exactly one `fire` pulse.
- R9: A cycle with `flush` high fires, on the next clock, every vector that has a request pending or present, regardless of its counter. Vectors without a request do not fire. Fired vectors reload their interval.
- R10: A vector with no request pending never fires, even when its counter expires or `flush` is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle base time tick that feeds the prescaler |
| req | input | NUM_VEC | Per-vector interrupt request |
| res_we | input | 1 | Write strobe for the shared resolution |
| res_val | input | RES_W | New resolution value N |
| intv_we | input | 1 | Write strobe for one vector's interval |
| intv_sel | input | SEL_W | Binary index of the vector whose interval is written |
| intv_val | input | CNT_W | New interval in resolution units, 0 = bypass |
| flush | input | 1 | Moderation reset strobe: release all waiting requests |
| fire | output | NUM_VEC | Per-vector one-cycle delivery pulse |

## Verification
A counter that loads the wrong value or decrements at the wrong rate moves the delivery of a held request earlier or later by whole prescaler periods. This shows on `fire` on the clock after the expected expiry. A prescaler phase left stale by a resolution write shifts that expiry by up to N base ticks. A pending flag that is lost or never cleared shows within one clock of a flush or an expiry: a missing pulse in the first case, an extra pulse in the second. The directed scenarios place a sample just before and just after each expected delivery so that an off-by-one edge is caught.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;

  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned RES_W_DEF = 8;

  // next prescaler phase: wraps to zero when it reaches the resolution
  function automatic logic [RES_W_DEF-1:0] phase_next(input logic [RES_W_DEF-1:0] ph,
                                                      input logic [RES_W_DEF-1:0] res);
    return (ph == res) ? '0 : ph + RES_W_DEF'(1);
  endfunction

  // countdown step that saturates at zero
  function automatic logic [CNT_W_DEF-1:0] count_step(input logic [CNT_W_DEF-1:0] c,
                                                      input logic en);
    return (en && c != '0) ? c - CNT_W_DEF'(1) : c;
  endfunction

endpackage

// File: rtl/irqmod_prescaler.sv
module irqmod_prescaler
  import irqmod_pkg::*;
#(
  parameter int unsigned RES_W = RES_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             res_we,
  input  logic [RES_W-1:0] res_val,
  output logic             step_en
);

  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] phase_q;
  logic             at_wrap;

  assign at_wrap = (phase_q == res_q);
  assign step_en = base_tick && at_wrap && !res_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      phase_q <= '0;
    end else if (res_we) begin
      res_q   <= res_val;
      phase_q <= '0;
    end else if (base_tick) begin
      phase_q <= phase_next(phase_q, res_q);
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= res_q); // R2
  AST_RES_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> (phase_q == '0 && res_q == $past(res_val))); // R3
  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_tick || res_we) |-> !step_en); // R3

endmodule

// File: rtl/irqmod_vec.sv
module irqmod_vec
  import irqmod_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             flush,
  input  logic             req,
  input  logic             intv_we,
  input  logic [CNT_W-1:0] intv_val,
  output logic             fire
);

  logic [CNT_W-1:0] intv_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             fire_q;

  // named internal events
  logic want;
  logic expired;
  logic deliver;

  assign want    = pend_q || req;
  assign expired = (cnt_q == '0);
  assign deliver = want && (expired || flush);
  assign fire    = fire_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intv_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      if (intv_we) intv_q <= intv_val;
      fire_q <= deliver;
      pend_q <= deliver ? 1'b0 : want;
      cnt_q  <= deliver ? intv_q : count_step(cnt_q, step_en);
    end
  end

  AST_IDLE_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cnt_q == '0) |=> fire_q); // R6
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (cnt_q == $past(intv_q))); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !flush) |=> !fire_q); // R7
  AST_FLUSH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && (pend_q || req)) |=> fire_q); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !req) |=> !fire_q); // R10
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (intv_q == '0 && req && !intv_we) |=> fire_q); // R5

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irqmod_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned RES_W   = RES_W_DEF,
  localparam int unsigned SEL_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_tick,
  input  logic [NUM_VEC-1:0] req,
  input  logic               res_we,
  input  logic [RES_W-1:0]   res_val,
  input  logic               intv_we,
  input  logic [SEL_W-1:0]   intv_sel,
  input  logic [CNT_W-1:0]   intv_val,
  input  logic               flush,
  output logic [NUM_VEC-1:0] fire
);

  logic               step_en;
  logic [NUM_VEC-1:0] intv_hit;

  irqmod_prescaler #(.RES_W(RES_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick),
    .res_we    (res_we),
    .res_val   (res_val),
    .step_en   (step_en)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign intv_hit[v] = intv_we && (intv_sel == SEL_W'(v));

    irqmod_vec #(.CNT_W(CNT_W)) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .flush    (flush),
      .req      (req[v]),
      .intv_we  (intv_hit[v]),
      .intv_val (intv_val),
      .fire     (fire[v])
    );
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(intv_hit)); // R4

endmodule

// File: tb/irq_moderator_bench.sv
`timescale 1ns/1ps
module irq_moderator_bench;

  localparam int NV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          base_tick = 1'b0;
  logic [NV-1:0] req = '0;
  logic          res_we = 1'b0;
  logic [7:0]    res_val = '0;
  logic          intv_we = 1'b0;
  logic [1:0]    intv_sel = '0;
  logic [7:0]    intv_val = '0;
  logic          flush = 1'b0;
  logic [NV-1:0] fire;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_moderator #(.NUM_VEC(NV)) u_irq_moderator (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .req(req),
    .res_we(res_we), .res_val(res_val), .intv_we(intv_we),
    .intv_sel(intv_sel), .intv_val(intv_val), .flush(flush), .fire(fire)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    base_tick = 1'b1; step(); base_tick = 1'b0;
  endtask

  task automatic pulse_req(input logic [NV-1:0] m);
    req = m; step(); req = '0;
  endtask

  task automatic set_intv(input int v, input logic [7:0] val);
    intv_we = 1'b1; intv_sel = 2'(v); intv_val = val; step(); intv_we = 1'b0;
  endtask

  task automatic set_res(input logic [7:0] val);
    res_we = 1'b1; res_val = val; step(); res_we = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    check("R1 fire after reset", 32'(fire), 32'h0);
    step();
    check("R1 idle", 32'(fire), 32'h0);
    pulse_req(4'hF);
    check("R1 zero intervals deliver", 32'(fire), 32'hF);
    step();
    check("R10 no request no pulse", 32'(fire), 32'h0);
  endtask

  task automatic t_bypass();
    set_intv(0, 8'd0);
    req = 4'b0001;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R5 bypass each clock", 32'(fire), 32'h1);
    end
    req = '0; step();
    check("R10 quiet after bypass", 32'(fire), 32'h0);
  endtask

  task automatic t_hold();
    set_res(8'd0);
    set_intv(1, 8'd3);
    pulse_req(4'b0010);
    check("R6 idle request fires", 32'(fire), 32'h2);
    step();
    check("R6 one-cycle pulse", 32'(fire), 32'h0);
    pulse_req(4'b0010);
    check("R7 held at request", 32'(fire), 32'h0);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R7 held during countdown", 32'(fire), 32'h0);
    end
    step();
    check("R7 release after expiry", 32'(fire), 32'h2);
    step();
    check("R7 single pulse", 32'(fire), 32'h0);
  endtask

  task automatic t_merge();
    int pulses = 0;
    for (int i = 0; i < 3; i++) begin
      pulse_req(4'b0010);
      check("R8 held while merging", 32'(fire), 32'h0);
    end
    for (int i = 0; i < 3; i++) tick();
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) tick(); else step();
      if (fire[1]) pulses++;
    end
    check("R8 merged into one pulse", 32'(pulses), 32'd1);
    check("R10 no pulse on expiry without request", 32'(fire), 32'h0);
  endtask

  task automatic t_resolution();
    set_res(8'd2);
    set_intv(2, 8'd2);
    pulse_req(4'b0100);
    check("R6 vec2 first delivery", 32'(fire), 32'h4);
    pulse_req(4'b0100);
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R2 not yet at N+1 rate", 32'(fire), 32'h0);
    end
    tick();
    check("R2 expiry edge no pulse yet", 32'(fire), 32'h0);
    step();
    check("R2 delivered after 2*(N+1) ticks", 32'(fire), 32'h4);
  endtask

  task automatic t_restart();
    set_res(8'd1);
    set_intv(3, 8'd1);
    pulse_req(4'b1000);
    check("R6 vec3 first delivery", 32'(fire), 32'h8);
    pulse_req(4'b1000);
    tick();
    set_res(8'd1);
    tick();
    step();
    check("R3 phase restarted no expiry", 32'(fire), 32'h0);
    tick();
    step();
    check("R3 expiry after restart", 32'(fire), 32'h8);
    // tick coinciding with a resolution write does not count
    pulse_req(4'b1000);
    tick(); // phase 0 -> 1
    res_we = 1'b1; res_val = 8'd1; base_tick = 1'b1; step();
    res_we = 1'b0; base_tick = 1'b0; step();
    check("R3 tick during write ignored", 32'(fire), 32'h0);
    tick(); tick(); step();
    check("R3 delivery after new phase", 32'(fire), 32'h8);
  endtask

  task automatic t_flush();
    set_res(8'd0);
    set_intv(1, 8'd200);
    set_intv(2, 8'd200);
    pulse_req(4'b0110);
    check("R6 vec1 vec2 deliver", 32'(fire), 32'h6);
    pulse_req(4'b0010);
    check("R7 vec1 held", 32'(fire), 32'h0);
    pulse_req(4'b0001);
    check("R4 vec0 independent bypass", 32'(fire), 32'h1);
    flush = 1'b1; step(); flush = 1'b0;
    check("R9 flush releases pending only", 32'(fire), 32'h2);
    step();
    check("R9 single flush pulse", 32'(fire), 32'h0);
    pulse_req(4'b0010);
    check("R9 counter reloaded by flush", 32'(fire), 32'h0);
    req = 4'b0100; flush = 1'b1; step(); req = '0; flush = 1'b0;
    check("R9 flush with same-cycle request", 32'(fire), 32'h6);
    flush = 1'b1; step(); flush = 1'b0;
    check("R10 flush with nothing pending", 32'(fire), 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_bypass();
    t_hold();
    t_merge();
    t_resolution();
    t_restart();
    t_flush();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule